// File: doc/BRIEF.md
# Partial-Word Store Lane Generator

This block turns a "store bytes" request into a single write beat for a 32-bit, big-endian, word-organised memory. A request carries a base address, a small signed displacement, a 32-bit register value, a fill-mode select and a base-modify flag. The block works out the effective byte address and produces four things: the word address, a byte-enable mask, lane-aligned write data, and a flag that marks the case where no byte is written.

In begin mode the write covers the tail of the word, from the addressed byte to the last byte. In end mode it covers the head of the word, from byte 0 up to the byte just below the address. Every write, including the three-byte cases, goes out as one beat with all of its enables. The byte that is not enabled therefore stays untouched and the update is indivisible.

When base modification is requested, the block also returns the updated base, rounded down to a word boundary. All outputs are registered and appear one cycle after the request.

Top module: `stby_lane_gen`

## Requirements
- R1: Begin mode (req_end_mode=0) with effective offset o = address[1:0] writes byte offsets o..3 of the word. Byte offset k maps to wr_byte_en[3-k] and wr_data[31-8k -: 8], so wr_byte_en = 4'b1111 >> o. Offset 3 writes only the least significant byte of the value, and offset 0 writes the whole word.
- R2: End mode (req_end_mode=1) with o != 0 writes byte offsets 0..o-1, which are the o bytes just below the address. They receive the o most significant bytes of the value, with the top byte at offset 0.
- R3: End mode with o = 0 gives wr_byte_en = 0 and raises wr_none. wr_valid is still raised so that the access check takes place. In all other cases wr_none is 0.
- R4: wr_data carries each enabled byte in its own lane, taken without shifting from the same bit position of req_value. Every lane that is not enabled reads zero.
- R5: wr_word_addr equals bits [31:2] of the effective address in every mode. All enabled bytes, three-byte writes included, are presented in one beat.
- R6: The effective address is req_base plus the sign-extended 5-bit req_disp when req_modify=0. When req_modify=1 it is req_base alone.
- R7: When req_modify=1, base_wr is 1 and new_base = (req_base + sext(req_disp)) with bits [1:0] cleared. When req_modify=0, base_wr is 0.
- R8: Outputs follow a request after exactly one clock. A cycle with req_valid=0 yields wr_valid=0, wr_byte_en=0, wr_none=0 and base_wr=0. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_end_mode | input | 1 | 0 = begin (fill tail of word), 1 = end (fill head of word) |
| req_modify | input | 1 | Use base as address and return updated base |
| req_base | input | 32 | Base byte address |
| req_disp | input | 5 | Signed displacement |
| req_value | input | 32 | Register value to store |
| wr_valid | output | 1 | Write or access-check beat |
| wr_word_addr | output | 30 | Word address |
| wr_byte_en | output | 4 | Byte enables, bit 3 = byte offset 0 |
| wr_data | output | 32 | Lane-aligned write data |
| wr_none | output | 1 | No bytes written, access check only |
| base_wr | output | 1 | new_base is valid |
| new_base | output | 32 | Updated, word-aligned base |

## Verification
The base update and the lane write come from separate units, and both are issued in the same output beat. The bench provokes this coincidence with modify requests that give a three-byte end-mode write and a no-store end-mode probe. In each such beat it judges the memory image, the wr_none flag and the rounded new_base together against a byte-array model. Back-to-back and idle cycles around these beats show that a request's base update never leaks into the following beat.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic {
    FILL_BEGIN = 1'b0,
    FILL_END   = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/stby_addr_calc.sv
module stby_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 5,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic              modify,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] upd_base
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;

  assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign sum      = base + disp_ext;
  assign eff_addr = modify ? base : sum;
  assign upd_base = {sum[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/stby_lane_mask.sv
module stby_lane_mask
  import stby_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic [OFF_W-1:0]  offset,
  input  fill_mode_e        mode,
  input  logic [DATA_W-1:0] value,
  output logic [NBYTES-1:0] byte_en,
  output logic [DATA_W-1:0] lane_data,
  output logic              none
);
  // byte offset k (big-endian) drives enable bit NBYTES-1-k
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam logic [OFF_W-1:0] KOFF = OFF_W'(k);
    logic lane_on;
    assign lane_on = (mode == FILL_BEGIN) ? (KOFF >= offset) : (KOFF < offset);
    assign byte_en[NBYTES-1-k] = lane_on;
    assign lane_data[DATA_W-1-8*k -: 8] = lane_on ? value[DATA_W-1-8*k -: 8] : 8'h00;
  end

  assign none = (mode == FILL_END) && (offset == '0);
endmodule

// File: rtl/stby_out_stage.sv
module stby_out_stage #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NBYTES  = 4,
  parameter int WADDR_W = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WADDR_W-1:0] in_waddr,
  input  logic [NBYTES-1:0]  in_be,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_none,
  input  logic               in_modify,
  input  logic [ADDR_W-1:0]  in_base,
  output logic               wr_valid,
  output logic [WADDR_W-1:0] wr_word_addr,
  output logic [NBYTES-1:0]  wr_byte_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_none,
  output logic               base_wr,
  output logic [ADDR_W-1:0]  new_base
);
  logic              valid_nxt, none_nxt, base_wr_nxt;
  logic [NBYTES-1:0] be_nxt;

  always_comb begin
    valid_nxt   = in_valid;
    be_nxt      = in_valid ? in_be : '0;
    none_nxt    = in_valid & in_none;
    base_wr_nxt = in_valid & in_modify;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_byte_en <= '0;
      wr_none    <= 1'b0;
      base_wr    <= 1'b0;
    end else begin
      wr_valid   <= valid_nxt;
      wr_byte_en <= be_nxt;
      wr_none    <= none_nxt;
      base_wr    <= base_wr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_word_addr <= '0;
      wr_data      <= '0;
      new_base     <= '0;
    end else if (in_valid) begin
      wr_word_addr <= in_waddr;
      wr_data      <= in_data;
      new_base     <= in_base;
    end
  end
endmodule

// File: rtl/stby_lane_gen.sv
module stby_lane_gen
  import stby_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 5,
  localparam int NBYTES  = DATA_W / 8,
  localparam int OFF_W   = $clog2(NBYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_end_mode,
  input  logic               req_modify,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [DISP_W-1:0]  req_disp,
  input  logic [DATA_W-1:0]  req_value,
  output logic               wr_valid,
  output logic [WADDR_W-1:0] wr_word_addr,
  output logic [NBYTES-1:0]  wr_byte_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_none,
  output logic               base_wr,
  output logic [ADDR_W-1:0]  new_base
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  fill_mode_e        mode;
  logic [ADDR_W-1:0] eff_addr, upd_base;
  logic [NBYTES-1:0] lane_be;
  logic [DATA_W-1:0] lane_data;
  logic              lane_none;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign mode = req_end_mode ? FILL_END : FILL_BEGIN;

  stby_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFF_W(OFF_W)) u_addr (
    .base     (req_base),
    .disp     (req_disp),
    .modify   (req_modify),
    .eff_addr (eff_addr),
    .upd_base (upd_base)
  );

  stby_lane_mask #(.NBYTES(NBYTES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_lane (
    .offset    (eff_addr[OFF_W-1:0]),
    .mode      (mode),
    .value     (req_value),
    .byte_en   (lane_be),
    .lane_data (lane_data),
    .none      (lane_none)
  );

  stby_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES), .WADDR_W(WADDR_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .in_valid     (req_valid),
    .in_waddr     (eff_addr[ADDR_W-1:OFF_W]),
    .in_be        (lane_be),
    .in_data      (lane_data),
    .in_none      (lane_none),
    .in_modify    (req_modify),
    .in_base      (upd_base),
    .wr_valid     (wr_valid),
    .wr_word_addr (wr_word_addr),
    .wr_byte_en   (wr_byte_en),
    .wr_data      (wr_data),
    .wr_none      (wr_none),
    .base_wr      (base_wr),
    .new_base     (new_base)
  );
endmodule

// File: rtl/stby_lane_gen_chk.sv
module stby_lane_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic              req_end_mode,
  input logic              req_modify,
  input logic              wr_valid,
  input logic [NBYTES-1:0] wr_byte_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_none,
  input logic              base_wr,
  input logic [ADDR_W-1:0] new_base
);
  logic [DATA_W-1:0] en_bits;
  always_comb begin
    for (int b = 0; b < NBYTES; b++) en_bits[8*b +: 8] = {8{wr_byte_en[b]}};
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> wr_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !wr_valid && wr_byte_en == '0 && !base_wr);
  a_r1_begin_low_lane: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && !req_end_mode |=> wr_byte_en[0] && !wr_none);
  a_r2_end_no_low_lane: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && req_end_mode |=> !wr_byte_en[0]);
  a_r3_none_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_none |-> wr_valid && wr_byte_en == '0);
  a_r4_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_valid |-> (wr_data & ~en_bits) == '0);
  a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_q_n)
    base_wr |-> new_base[OFF_W-1:0] == '0);
  a_r7_base_only_modify: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && !req_modify |=> !base_wr);
endmodule

bind stby_lane_gen stby_lane_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .req_valid    (req_valid),
  .req_end_mode (req_end_mode),
  .req_modify   (req_modify),
  .wr_valid     (wr_valid),
  .wr_byte_en   (wr_byte_en),
  .wr_data      (wr_data),
  .wr_none      (wr_none),
  .base_wr      (base_wr),
  .new_base     (new_base)
);

// File: tb/test_stby_lane_gen.sv
module test_stby_lane_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_end_mode, req_modify;
  logic [31:0] req_base, req_value;
  logic [4:0]  req_disp;
  logic        wr_valid, wr_none, base_wr;
  logic [29:0] wr_word_addr;
  logic [3:0]  wr_byte_en;
  logic [31:0] wr_data, new_base;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stby_lane_gen i_stby_lane_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_end_mode(req_end_mode),
    .req_modify(req_modify), .req_base(req_base), .req_disp(req_disp),
    .req_value(req_value), .wr_valid(wr_valid), .wr_word_addr(wr_word_addr),
    .wr_byte_en(wr_byte_en), .wr_data(wr_data), .wr_none(wr_none),
    .base_wr(base_wr), .new_base(new_base)
  );

  // {end, modify, base[31:0], disp[4:0], value[31:0]}
  localparam int NVEC = 13;
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_1000, 5'd0,  32'h1122_3344},
    {1'b0, 1'b0, 32'h0000_1001, 5'd0,  32'hA1B2_C3D4},
    {1'b0, 1'b0, 32'h0000_1002, 5'd0,  32'hCAFE_BEEF},
    {1'b0, 1'b0, 32'h0000_1003, 5'd0,  32'h0102_0377},
    {1'b1, 1'b0, 32'h0000_1000, 5'd0,  32'hDEAD_F00D},
    {1'b1, 1'b0, 32'h0000_1001, 5'd0,  32'h9988_7766},
    {1'b1, 1'b0, 32'h0000_1002, 5'd0,  32'h5566_7788},
    {1'b1, 1'b0, 32'h0000_1003, 5'd0,  32'hF1E2_D3C4},
    {1'b0, 1'b0, 32'h0000_2002, 5'd5,  32'h0BAD_C0DE},
    {1'b1, 1'b0, 32'h0000_3001, 5'h1A, 32'h1357_9BDF},
    {1'b1, 1'b1, 32'h0000_4003, 5'd7,  32'hABCD_EF01},
    {1'b0, 1'b1, 32'h0000_5006, 5'h1D, 32'h2468_ACE0},
    {1'b1, 1'b1, 32'h0000_6000, 5'd4,  32'h7777_8888}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [70:0] v);
    logic        em, md;
    logic [31:0] b, val, ea, sum, ref_img, dut_img;
    logic [4:0]  d;
    int          o, n;
    em = v[70]; md = v[69]; b = v[68:37]; d = v[36:32]; val = v[31:0];
    sum = b + {{27{d[4]}}, d};
    ea  = md ? b : sum;
    o   = int'(ea[1:0]);
    ref_img = 32'hA5A5_A5A5;
    dut_img = 32'hA5A5_A5A5;
    if (!em) begin
      n = 4 - o;
      for (int j = 0; j < n; j++) ref_img[31-8*(o+j) -: 8] = val[8*(n-1-j) +: 8];
    end else begin
      n = o;
      for (int j = 0; j < n; j++) ref_img[31-8*j -: 8] = val[31-8*j -: 8];
    end
    @(negedge clk);
    req_valid = 1'b1; req_end_mode = em; req_modify = md;
    req_base = b; req_disp = d; req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++)
      if (wr_byte_en[3-k]) dut_img[31-8*k -: 8] = wr_data[31-8*k -: 8];
    check(wr_valid == 1'b1, "R8 valid after one cycle", {31'd0, wr_valid}, 32'd1);
    check(wr_word_addr == ea[31:2], "R5/R6 word address", {2'b0, wr_word_addr}, {2'b0, ea[31:2]});
    check(dut_img == ref_img, em ? "R2/R3 end-mode memory image" : "R1 begin-mode memory image",
          dut_img, ref_img);
    check(wr_none == (em && o == 0), "R3 no-store flag", {31'd0, wr_none}, {31'd0, em && o == 0});
    for (int k = 0; k < 4; k++)
      if (!wr_byte_en[3-k])
        check(wr_data[31-8*k -: 8] == 8'h00, "R4 idle lane zero", {24'd0, wr_data[31-8*k -: 8]}, 32'd0);
    check(base_wr == md, "R7 base update flag", {31'd0, base_wr}, {31'd0, md});
    if (md) check(new_base == {sum[31:2], 2'b00}, "R7 new base", new_base, {sum[31:2], 2'b00});
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_end_mode = 1'b0; req_modify = 1'b0;
    req_base = '0; req_disp = '0; req_value = '0;
    repeat (3) @(negedge clk);
    check(wr_valid == 0 && wr_byte_en == 0 && wr_none == 0 && base_wr == 0 && wr_data == 0,
          "R8 reset state", {wr_byte_en, 28'd0} | {31'd0, wr_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // idle cycle after a modify request: nothing leaks forward
    @(negedge clk);
    check(wr_valid == 0 && wr_byte_en == 0 && base_wr == 0 && wr_none == 0,
          "R8 idle beat quiet", {27'd0, wr_valid, wr_byte_en}, 32'd0);

    // back-to-back: modify end-mode three-byte, then plain begin word
    @(negedge clk);
    req_valid = 1'b1; req_end_mode = 1'b1; req_modify = 1'b1;
    req_base = 32'h0000_7003; req_disp = 5'd2; req_value = 32'hC0C1_C2C3;
    @(negedge clk);
    check(wr_byte_en == 4'b1110 && wr_data == 32'hC0C1_C200, "R2 three-byte head in one beat",
          wr_data, 32'hC0C1_C200);
    check(base_wr && new_base == 32'h0000_7004, "R7 base with three-byte write", new_base, 32'h0000_7004);
    req_end_mode = 1'b0; req_modify = 1'b0; req_base = 32'h0000_8000; req_disp = 5'd0;
    req_value = 32'h0F0E_0D0C;
    @(negedge clk);
    req_valid = 1'b0;
    check(wr_byte_en == 4'b1111 && wr_data == 32'h0F0E_0D0C && !base_wr,
          "R1 full word after modify beat", wr_data, 32'h0F0E_0D0C);
    check(wr_word_addr == 30'h0000_2000, "R5 word address back-to-back", {2'b0, wr_word_addr}, 32'h2000);

    // reset mid-stream clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(wr_valid == 0 && wr_byte_en == 0, "R8 reset clears", {27'd0, wr_valid, wr_byte_en}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule